// File: doc/BRIEF.md
# Fully Associative Range Translation Cache

This block is a small first-level cache of range translations. A range translation maps every virtual page number in a half-open window `[base, limit)` onto a physical page number by adding one signed offset, and the whole window carries one permission value. Because a match is a bounds test and not a tag compare, a single entry covers any number of pages. The cache holds four such entries by default and compares all of them against the lookup page number in parallel.

It is probed in the same cycle as the page-based first-level TLB. A hit here supplies the translation directly, so the page TLB's miss path is not needed for that access. When neither structure hits, the next translation level sends an entry back on the refill port. The refill goes into the lowest-numbered empty slot if there is one. Otherwise it replaces the least recently used entry. A flush input empties the cache in one cycle.

Top module: `range_xlat_cache`

## Requirements
- R1: After synchronous reset no entry is valid, and `lk_hit`, `lk_ppn` and `lk_perm` read zero.
- R2: An entry matches a lookup when it is valid and `base <= vpn < limit`, compared as unsigned numbers. The limit is exclusive, and an entry whose base is not below its limit never matches.
- R3: One cycle after a lookup that matches, `lk_hit` is 1, `lk_ppn` equals the lookup page number plus the entry offset modulo 2^VPN_W (the offset is in two's complement), and `lk_perm` equals the entry's permission.
- R4: One cycle after a cycle with no lookup, or with a lookup that matches nothing, `lk_hit`, `lk_ppn` and `lk_perm` are all zero.
- R5: When several valid entries match, the entry with the lowest index supplies the result.
- R6: A refill is written into the lowest-index invalid entry whenever any entry is invalid.
- R7: When all entries are valid, a refill replaces the least recently used entry. Recency is updated by every lookup hit and by every accepted refill, and the written entry becomes most recent. If a hit and an accepted refill happen in the same cycle, only the refill updates recency. After reset, entry 0 is most recent and the highest index is least recent.
- R8: `flush` invalidates every entry at the next clock edge, so lookups from the following cycle on miss. A refill presented in the same cycle as `flush` is discarded. A lookup hit in that cycle still updates recency.
- R9: A refill becomes visible to lookups from the cycle after it is presented. A lookup in the same cycle as the refill sees the previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| fill_valid | input | 1 | Refill request this cycle |
| fill_base | input | VPN_W | First virtual page of the refilled range |
| fill_limit | input | VPN_W | One past the last virtual page of the range |
| fill_offset | input | VPN_W | Signed physical-minus-virtual page delta |
| fill_perm | input | PERM_W | Permission value of the range |
| flush | input | 1 | Invalidate all entries |
| lk_hit | output | 1 | Registered hit flag |
| lk_ppn | output | VPN_W | Registered translated page number, zero on miss |
| lk_perm | output | PERM_W | Registered permission, zero on miss |

## Verification
A valid bit that is wrong shows up as a spurious hit or a spurious miss on the first lookup that falls inside the affected window, one cycle after that lookup. Recency state that is wrong does not show at once. It appears only when a later refill evicts the wrong range, and a lookup into the surviving or evicted window then reports a hit or miss different from the reference model. For that reason, the random stimulus keeps ranges and lookups inside a narrow page window with frequent refills, so that evictions are soon followed by lookups that expose them. Priority and offset errors appear as a wrong `lk_ppn` in the cycle right after an overlapping or wrapping lookup.

// File: rtl/rtc_pkg.sv
// Shared defaults and types for the range translation cache.
// Assumes: consumers size their own storage from these defaults.
package rtc_pkg;
    parameter int unsigned RT_ENTRIES = 4;
    parameter int unsigned RT_VPN_W   = 36;
    parameter int unsigned RT_PERM_W  = 3;

    // Which event, if any, moves an entry to most-recent this cycle.
    typedef enum logic [1:0] {
        UPD_NONE = 2'd0,
        UPD_HIT  = 2'd1,
        UPD_FILL = 2'd2
    } rt_upd_t;
endpackage

// File: rtl/rtc_bound_cmp.sv
// Per-entry match and translation: bounds test plus offset add.
// Assumes: all values unsigned except the offset, which is two's complement
// and wraps modulo 2^VPN_W.
module rtc_bound_cmp #(
    parameter int unsigned VPN_W = 36
) (
    input  logic             ent_vld,
    input  logic [VPN_W-1:0] ent_lo,
    input  logic [VPN_W-1:0] ent_hi,
    input  logic [VPN_W-1:0] ent_off,
    input  logic [VPN_W-1:0] vpn,
    output logic             match,
    output logic [VPN_W-1:0] ppn_cand
);
    logic above_lo;
    logic below_hi;

    // Evaluate both window bounds and form the candidate translation.
    always_comb begin
        above_lo = (vpn >= ent_lo);
        below_hi = (vpn < ent_hi);
        match    = ent_vld && above_lo && below_hi;
        ppn_cand = vpn + ent_off;
    end
endmodule

// File: rtl/rtc_first_hit.sv
// Lowest-index priority selector over the per-entry match vector.
// Assumes: N >= 1; outputs are don't-care in value when any_hit is 0
// except that sel_oh is all zero.
module rtc_first_hit #(
    parameter int unsigned N     = 4,
    parameter int unsigned IDX_W = 2
) (
    input  logic [N-1:0]     hits,
    output logic [N-1:0]     sel_oh,
    output logic [IDX_W-1:0] sel_idx,
    output logic             any_hit
);
    // Isolate the lowest set bit and encode its position.
    always_comb begin
        sel_oh  = hits & ~(hits - N'(1));
        any_hit = |hits;
        sel_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits[i]) sel_idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/rtc_recency.sv
// Age-based recency tracker and refill victim chooser.
// Ages form a permutation of 0..N-1 (0 = most recent). The victim is the
// lowest invalid entry, or the entry of age N-1 when all are valid.
// Assumes: touch_idx is meaningful only when upd_src is UPD_HIT.
module rtc_recency
    import rtc_pkg::*;
#(
    parameter int unsigned N     = 4,
    parameter int unsigned IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     vld_vec,
    input  rt_upd_t          upd_src,
    input  logic [IDX_W-1:0] touch_idx,
    output logic [IDX_W-1:0] victim_idx,
    output logic [N-1:0]     victim_oh
);
    logic [IDX_W-1:0] age_q [N];
    logic [IDX_W-1:0] tgt_idx;
    logic [IDX_W-1:0] tgt_age;
    logic             found_free;

    // Choose the refill target: first free slot, else the oldest entry.
    always_comb begin
        found_free = 1'b0;
        victim_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (!vld_vec[i] && !found_free) begin
                victim_idx = IDX_W'(i);
                found_free = 1'b1;
            end
        end
        if (!found_free) begin
            for (int i = 0; i < N; i++) begin
                if (age_q[i] == IDX_W'(N - 1)) victim_idx = IDX_W'(i);
            end
        end
        victim_oh = '0;
        victim_oh[victim_idx] = 1'b1;
    end

    // Pick which entry becomes most recent and its current age.
    always_comb begin
        tgt_idx = (upd_src == UPD_FILL) ? victim_idx : touch_idx;
        tgt_age = age_q[tgt_idx];
    end

    // Age every entry younger than the touched one; touched becomes 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) age_q[i] <= IDX_W'(i);
        end else if (upd_src != UPD_NONE) begin
            for (int i = 0; i < N; i++) begin
                if (IDX_W'(i) == tgt_idx)  age_q[i] <= '0;
                else if (age_q[i] < tgt_age) age_q[i] <= age_q[i] + IDX_W'(1);
            end
        end
    end
endmodule

// File: rtl/range_xlat_cache.sv
// Fully associative range translation cache, top level.
// Holds ENTRIES ranges [lo, hi) with an offset and permission each; all are
// compared in parallel, lowest index wins, result registered one cycle later.
// Assumes: software keeps valid ranges disjoint (overlap is resolved by
// index only); flush outranks refill; refill writes take effect next cycle.
module range_xlat_cache
    import rtc_pkg::*;
#(
    parameter int unsigned ENTRIES = RT_ENTRIES,
    parameter int unsigned VPN_W   = RT_VPN_W,
    parameter int unsigned PERM_W  = RT_PERM_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic              fill_valid,
    input  logic [VPN_W-1:0]  fill_base,
    input  logic [VPN_W-1:0]  fill_limit,
    input  logic [VPN_W-1:0]  fill_offset,
    input  logic [PERM_W-1:0] fill_perm,
    input  logic              flush,
    output logic              lk_hit,
    output logic [VPN_W-1:0]  lk_ppn,
    output logic [PERM_W-1:0] lk_perm
);
    localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0] vld_q;
    logic [VPN_W-1:0]   lo_q   [ENTRIES];
    logic [VPN_W-1:0]   hi_q   [ENTRIES];
    logic [VPN_W-1:0]   off_q  [ENTRIES];
    logic [PERM_W-1:0]  perm_q [ENTRIES];

    logic [ENTRIES-1:0] hit_vec;
    logic [VPN_W-1:0]   ppn_cand [ENTRIES];
    logic [ENTRIES-1:0] sel_oh;
    logic [IDX_W-1:0]   sel_idx;
    logic               sel_any;
    logic [VPN_W-1:0]   ppn_mux;
    logic [PERM_W-1:0]  perm_mux;
    logic               fill_take;
    logic               lk_match;
    rt_upd_t            upd_src;
    logic [IDX_W-1:0]   victim_idx;
    logic [ENTRIES-1:0] victim_oh;

    // Per-entry comparators, one per slot.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        rtc_bound_cmp #(.VPN_W(VPN_W)) u_cmp (
            .ent_vld  (vld_q[g]),
            .ent_lo   (lo_q[g]),
            .ent_hi   (hi_q[g]),
            .ent_off  (off_q[g]),
            .vpn      (lk_vpn),
            .match    (hit_vec[g]),
            .ppn_cand (ppn_cand[g])
        );
    end

    rtc_first_hit #(.N(ENTRIES), .IDX_W(IDX_W)) u_first (
        .hits    (hit_vec),
        .sel_oh  (sel_oh),
        .sel_idx (sel_idx),
        .any_hit (sel_any)
    );

    // AND-OR mux of the winning entry's translation and permission.
    always_comb begin
        ppn_mux  = '0;
        perm_mux = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (sel_oh[i]) begin
                ppn_mux  = ppn_mux | ppn_cand[i];
                perm_mux = perm_mux | perm_q[i];
            end
        end
    end

    // Decide which event updates recency this cycle.
    always_comb begin
        fill_take = fill_valid && !flush;
        lk_match  = lk_valid && sel_any;
        if (fill_take)     upd_src = UPD_FILL;
        else if (lk_match) upd_src = UPD_HIT;
        else               upd_src = UPD_NONE;
    end

    rtc_recency #(.N(ENTRIES), .IDX_W(IDX_W)) u_rec (
        .clk        (clk),
        .rst_n      (rst_n),
        .vld_vec    (vld_q),
        .upd_src    (upd_src),
        .touch_idx  (sel_idx),
        .victim_idx (victim_idx),
        .victim_oh  (victim_oh)
    );

    // Entry storage: flush clears all, else a refill writes the victim.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            for (int i = 0; i < ENTRIES; i++) begin
                lo_q[i]   <= '0;
                hi_q[i]   <= '0;
                off_q[i]  <= '0;
                perm_q[i] <= '0;
            end
        end else if (flush) begin
            vld_q <= '0;
        end else if (fill_valid) begin
            vld_q[victim_idx]  <= 1'b1;
            lo_q[victim_idx]   <= fill_base;
            hi_q[victim_idx]   <= fill_limit;
            off_q[victim_idx]  <= fill_offset;
            perm_q[victim_idx] <= fill_perm;
        end
    end

    // Result register: zeroed on miss or idle cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_hit  <= 1'b0;
            lk_ppn  <= '0;
            lk_perm <= '0;
        end else begin
            lk_hit  <= lk_match;
            lk_ppn  <= lk_match ? ppn_mux : '0;
            lk_perm <= lk_match ? perm_mux : '0;
        end
    end
endmodule

// File: rtl/rtc_checker.sv
// Assertion checker for range_xlat_cache, attached by bind below.
// Assumes: internal vectors are connected through the bind port list.
module rtc_checker #(
    parameter int unsigned N      = 4,
    parameter int unsigned VPN_W  = 36,
    parameter int unsigned PERM_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lk_valid,
    input logic              lk_hit,
    input logic [VPN_W-1:0]  lk_ppn,
    input logic [PERM_W-1:0] lk_perm,
    input logic              flush,
    input logic              fill_valid,
    input logic [N-1:0]      vld_q,
    input logic [N-1:0]      sel_oh,
    input logic [N-1:0]      victim_oh
);
    // R4
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_ppn == '0 && lk_perm == '0));

    // R3
    hit_needs_lookup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> $past(lk_valid));

    // R8
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (vld_q == '0));

    // R5
    first_hit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_oh));

    // R7
    victim_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(victim_oh) == 1);

    // R6
    victim_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_q != {N{1'b1}}) |-> ((victim_oh & vld_q) == '0));

    // R9
    fill_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !flush) |=> (vld_q != '0));
endmodule

bind range_xlat_cache rtc_checker #(
    .N(ENTRIES), .VPN_W(VPN_W), .PERM_W(PERM_W)
) u_rtc_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_valid   (lk_valid),
    .lk_hit     (lk_hit),
    .lk_ppn     (lk_ppn),
    .lk_perm    (lk_perm),
    .flush      (flush),
    .fill_valid (fill_valid),
    .vld_q      (vld_q),
    .sel_oh     (sel_oh),
    .victim_oh  (victim_oh)
);

// File: tb/test_range_xlat_cache.sv
// Self-checking bench: reference model plus directed and seeded random cycles.
module test_range_xlat_cache;
    localparam int ENT = 4;
    localparam int VW  = 36;
    localparam int PW  = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lk_valid = 1'b0;
    logic [VW-1:0] lk_vpn = '0;
    logic          fill_valid = 1'b0;
    logic [VW-1:0] fill_base = '0, fill_limit = '0, fill_offset = '0;
    logic [PW-1:0] fill_perm = '0;
    logic          flush = 1'b0;
    logic          lk_hit;
    logic [VW-1:0] lk_ppn;
    logic [PW-1:0] lk_perm;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference model state.
    bit            m_vld  [ENT];
    logic [VW-1:0] m_lo   [ENT];
    logic [VW-1:0] m_hi   [ENT];
    logic [VW-1:0] m_off  [ENT];
    logic [PW-1:0] m_perm [ENT];
    int            m_age  [ENT];

    always #2.5 clk = ~clk;  // 200 MHz

    range_xlat_cache i_range_xlat_cache (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vpn(lk_vpn),
        .fill_valid(fill_valid), .fill_base(fill_base), .fill_limit(fill_limit),
        .fill_offset(fill_offset), .fill_perm(fill_perm), .flush(flush),
        .lk_hit(lk_hit), .lk_ppn(lk_ppn), .lk_perm(lk_perm)
    );

    function automatic void model_reset();
        for (int i = 0; i < ENT; i++) begin
            m_vld[i] = 0; m_lo[i] = '0; m_hi[i] = '0; m_off[i] = '0;
            m_perm[i] = '0; m_age[i] = i;
        end
    endfunction

    function automatic void model_lookup(input logic [VW-1:0] vpn,
                                         output bit h, output int idx);
        h = 0; idx = 0;
        for (int i = 0; i < ENT; i++) begin
            if (!h && m_vld[i] && vpn >= m_lo[i] && vpn < m_hi[i]) begin
                h = 1; idx = i;
            end
        end
    endfunction

    function automatic int model_victim();
        for (int i = 0; i < ENT; i++) if (!m_vld[i]) return i;
        for (int i = 0; i < ENT; i++) if (m_age[i] == ENT - 1) return i;
        return 0;
    endfunction

    function automatic void model_touch(input int t);
        int ta = m_age[t];
        for (int i = 0; i < ENT; i++) begin
            if (i == t) m_age[i] = 0;
            else if (m_age[i] < ta) m_age[i] = m_age[i] + 1;
        end
    endfunction

    task automatic check_out(input bit eh, input logic [VW-1:0] ep,
                             input logic [PW-1:0] eperm, input string tag);
        checks++;
        if (lk_hit !== eh || lk_ppn !== ep || lk_perm !== eperm) begin
            errors++;
            $display("FAIL %s: got hit=%0b ppn=%0h perm=%0h, expected hit=%0b ppn=%0h perm=%0h",
                     tag, lk_hit, lk_ppn, lk_perm, eh, ep, eperm);
        end
    endtask

    // One clock: drive at negedge, update model at posedge, check at next negedge.
    task automatic step(input bit lv, input logic [VW-1:0] vpn,
                        input bit fv, input logic [VW-1:0] lo, input logic [VW-1:0] hi,
                        input logic [VW-1:0] off, input logic [PW-1:0] perm,
                        input bit fl, input string tag);
        bit h; int idx; int vic;
        bit eh; logic [VW-1:0] ep; logic [PW-1:0] eperm;
        lk_valid = lv; lk_vpn = vpn; fill_valid = fv; fill_base = lo;
        fill_limit = hi; fill_offset = off; fill_perm = perm; flush = fl;
        model_lookup(vpn, h, idx);
        eh = lv && h;
        ep = eh ? vpn + m_off[idx] : '0;
        eperm = eh ? m_perm[idx] : '0;
        vic = model_victim();
        @(posedge clk);
        if (fv && !fl) begin
            m_vld[vic] = 1; m_lo[vic] = lo; m_hi[vic] = hi;
            m_off[vic] = off; m_perm[vic] = perm;
            model_touch(vic);
        end else if (eh) begin
            model_touch(idx);
        end
        if (fl) for (int i = 0; i < ENT; i++) m_vld[i] = 0;
        @(negedge clk);
        check_out(eh, ep, eperm, tag);
    endtask

    task automatic look(input logic [VW-1:0] vpn, input string tag);
        step(1, vpn, 0, '0, '0, '0, '0, 0, tag);
    endtask

    task automatic fill(input logic [VW-1:0] lo, input logic [VW-1:0] hi,
                        input logic [VW-1:0] off, input logic [PW-1:0] perm, input string tag);
        step(0, '0, 1, lo, hi, off, perm, 0, tag);
    endtask

    initial begin
        process::self().srandom(32'h5eed_2024);
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: outputs zero after reset, nothing hits
        checks++;
        if (lk_hit !== 1'b0 || lk_ppn !== '0 || lk_perm !== '0) begin
            errors++;
            $display("FAIL R1: got hit=%0b ppn=%0h perm=%0h, expected 0 0 0", lk_hit, lk_ppn, lk_perm);
        end
        look(36'd0, "R1 empty cache lookup");
        look(36'd105, "R4 miss on empty cache");

        // R6: first refill goes to entry 0, bounds and offset
        fill(36'd100, 36'd110, 36'd1000, 3'd5, "R6 first refill");
        look(36'd100, "R2 lower bound inclusive");
        look(36'd109, "R3 ppn = vpn + offset");
        look(36'd110, "R2 limit exclusive");
        look(36'd99, "R4 below base misses");
        // R3: negative offset and wrap
        fill(36'd200, 36'd300, -36'sd150, 3'd2, "R6 second refill");
        look(36'd250, "R3 negative offset");
        fill(36'd10, 36'd20, 36'hF_FFFF_FFF8, 3'd7, "R6 third refill");
        look(36'd12, "R3 offset wraps modulo");
        // R9: lookup in the fill cycle sees old contents, then hits
        step(1, 36'd405, 1, 36'd400, 36'd410, 36'd7, 3'd1, 0, "R9 same-cycle fill invisible");
        look(36'd405, "R9 fill visible next cycle");
        // R7: all valid, touch 0,1,3 so entry 2 is oldest
        look(36'd100, "R7 touch entry 0");
        look(36'd200, "R7 touch entry 1");
        look(36'd400, "R7 touch entry 3");
        fill(36'd500, 36'd520, 36'd3, 3'd4, "R7 evicting refill");
        look(36'd15, "R7 oldest range evicted");
        look(36'd510, "R7 new range present");
        // R5: overlap resolved by index
        fill(36'd505, 36'd600, 36'd9000, 3'd6, "R7 second evicting refill");
        look(36'd507, "R5 lowest index wins on overlap");
        // R2: empty range never hits
        fill(36'd700, 36'd700, 36'd1, 3'd1, "R2 empty range refill");
        look(36'd700, "R2 empty range misses");
        // R8: flush with concurrent refill and hit
        step(1, 36'd505, 1, 36'd800, 36'd900, 36'd1, 3'd3, 1, "R8 hit during flush");
        look(36'd850, "R8 refill during flush dropped");
        look(36'd505, "R8 all entries cleared");
        fill(36'd800, 36'd900, 36'd1, 3'd3, "R6 refill after flush");
        look(36'd850, "R6 refill after flush hits");

        // Random mix in a narrow window.
        for (int n = 0; n < 4000; n++) begin
            bit lv, fv, fl;
            logic [VW-1:0] vpn, lo, hi, off;
            lv  = ($urandom_range(0, 99) < 80);
            fv  = ($urandom_range(0, 99) < 12);
            fl  = ($urandom_range(0, 199) == 0);
            vpn = ($urandom_range(0, 9) == 0) ? VW'({$urandom, $urandom}) : VW'($urandom_range(0, 600));
            lo  = VW'($urandom_range(0, 511));
            hi  = lo + VW'($urandom_range(0, 64));
            off = VW'({$urandom, $urandom});
            step(lv, vpn, fv, lo, hi, off, PW'($urandom), fl, "R2/R3/R7 random");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule